// File: doc/BRIEF.md
# Binarized Multichannel 3x3 Convolution Engine

This block computes one layer tile of a convolutional network on a pixel stream. Each stream beat carries one pixel position from eight input feature maps at once, in raster order. Two line memories and a 3x3 register window keep the neighbourhood of every channel. Each of eight output channels adds or subtracts every tap of every input channel according to a single-bit sign weight, so no multiplier is spent on the kernel. A per-channel scale and bias then apply the folded batch normalization, and the result is saturated to 16 bits. The eight results for one position leave together on the output stream.

The image is padded with one ring of zeros, so each output map has the same width and height as the input maps. After the last input beat of a frame the engine generates its own zero beats to push out the final row, and it marks the last output pixel with `m_tlast`. Frame size, sign weights, scales and biases are written through a small register port while the engine is idle. Input and output transfer at the same time. When the output is not accepted the whole pipeline holds and the input is refused.

Top module: `binconv3x3_engine`

## Requirements
- R1: After reset is released, `m_tvalid` is low and `s_tready` is high.
- R2: Output channel o at row r, column c equals the sum, over input channels i and taps (dy,dx) in {-1,0,1}, of +p or -p, where p is input channel i at (r+dy, c+dx), or 0 when that position lies outside the image. The sign comes from the 9-bit word at register address 0x40 + 8*o + i: bit 3*(dy+1)+(dx+1) set means +p, clear means -p.
- R3: The sum from R2 is multiplied by the signed 16-bit scale at address 0x80 + o, arithmetically shifted right by 8, and the signed 16-bit bias at address 0x88 + o is added. The result is clamped to [-32768, 32767].
- R4: Address 0x00 holds the width and address 0x01 the height, each from 1 to 64. Every frame of width*height input beats yields exactly width*height output beats in raster order, and no further output beat.
- R5: `m_tlast` is high on the last output beat of each frame and low on every other output beat.
- R6: While `m_tvalid` is high and `m_tready` is low, `s_tready` is low and `m_tdata` and `m_tlast` hold their values. No input beat is lost.
- R7: Register writes made while a frame is in progress (from its first accepted input beat until its last output beat is accepted) are ignored.
- R8: Input channel k uses bits [16k+15:16k] of `s_tdata`, and output channel k uses bits [16k+15:16k] of `m_tdata`.
- R9: Frames follow one another with no reset between them, including frames of a different size, and no data from an earlier frame reaches the outputs of a later one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 16 | Register write data |
| s_tvalid | input | 1 | Input beat valid |
| s_tready | output | 1 | Input beat accepted |
| s_tdata | input | 128 | Eight 16-bit input pixels |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Output beat accepted |
| m_tdata | output | 128 | Eight 16-bit output pixels |
| m_tlast | output | 1 | Last output pixel of the frame |

## Verification
The hardest situation to reach is the tail of a frame. There the engine feeds itself zero beats while the consumer stalls, the line memories still hold rows of the previous, differently sized frame, and the window holds taps that must be masked at the top, bottom and both side borders. The stimulus table runs frames back to back, from 64-wide down to 1x1 and a single column, with random pauses on both streams. Every output pixel is compared against a reference built from the padded-sum definition. Separate directed frames drive full-scale pixels to hit both saturation limits and try register writes in the middle of a frame.

// File: rtl/binconv_pkg.sv
package binconv_pkg;
  // Taps in the fixed 3x3 kernel; tap index = 3*row + column, row 0 on top.
  localparam int TAPS = 9;
  // Register map of the configuration port.
  localparam logic [7:0] A_WIDTH      = 8'h00;
  localparam logic [7:0] A_HEIGHT     = 8'h01;
  localparam logic [7:0] A_WGT_BASE   = 8'h40;
  localparam logic [7:0] A_SCALE_BASE = 8'h80;
  localparam logic [7:0] A_BIAS_BASE  = 8'h88;
endpackage

// File: rtl/binconv_cfg.sv
module binconv_cfg
  import binconv_pkg::*;
#(
  parameter int NI   = 8,
  parameter int NO   = 8,
  parameter int DW   = 16,
  parameter int SH   = 8,
  parameter int MAXW = 64,
  parameter int MAXH = 64,
  localparam int CW  = $clog2(MAXW + 1),
  localparam int HW  = $clog2(MAXH + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   busy,
  input  logic                   we,
  input  logic [7:0]             addr,
  input  logic [DW-1:0]          wdata,
  output logic [CW-1:0]          width,
  output logic [HW-1:0]          height,
  output logic [NO*NI*TAPS-1:0]  wgt,
  output logic [NO*DW-1:0]       scale,
  output logic [NO*DW-1:0]       bias
);
  logic wr_ok;
  assign wr_ok = we && !busy;

  logic [CW-1:0] width_q;
  logic [HW-1:0] height_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) width_q <= CW'(MAXW);
    else if (wr_ok && addr == A_WIDTH) width_q <= wdata[CW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) height_q <= HW'(MAXH);
    else if (wr_ok && addr == A_HEIGHT) height_q <= wdata[HW-1:0];
  end

  assign width  = width_q;
  assign height = height_q;

  // One 9-bit sign word per (output, input) channel pair.
  for (genvar g = 0; g < NO * NI; g++) begin : g_wgt
    logic [TAPS-1:0] w_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= '0;
      else if (wr_ok && addr == A_WGT_BASE + 8'(g)) w_q <= wdata[TAPS-1:0];
    end
    assign wgt[g*TAPS +: TAPS] = w_q;
  end

  for (genvar o = 0; o < NO; o++) begin : g_aff
    logic [DW-1:0] s_q, b_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_q <= DW'(1) << SH;
      else if (wr_ok && addr == A_SCALE_BASE + 8'(o)) s_q <= wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) b_q <= '0;
      else if (wr_ok && addr == A_BIAS_BASE + 8'(o)) b_q <= wdata;
    end
    assign scale[o*DW +: DW] = s_q;
    assign bias[o*DW +: DW]  = b_q;
  end

  // A write during a frame must leave the frame size untouched.
  assert_cfg_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we && busy) |=> ($stable(width_q) && $stable(height_q)));
endmodule

// File: rtl/binconv_window.sv
module binconv_window
  import binconv_pkg::*;
#(
  parameter int NI   = 8,
  parameter int DW   = 16,
  parameter int MAXW = 64,
  localparam int AW  = $clog2(MAXW),
  localparam int VW  = NI * DW
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               step,
  input  logic [AW-1:0]      col,
  input  logic [VW-1:0]      pix,
  output logic [TAPS*VW-1:0] win
);
  // Line memories: mem_up1 holds the row above the incoming one, mem_up2 two rows above.
  logic [VW-1:0] mem_up1 [MAXW];
  logic [VW-1:0] mem_up2 [MAXW];
  logic [VW-1:0] rd_up1, rd_up2;

  assign rd_up1 = mem_up1[col];
  assign rd_up2 = mem_up2[col];

  // RAM-style storage, no reset: stale rows are masked by the border logic.
  always_ff @(posedge clk) begin
    if (step) begin
      mem_up1[col] <= pix;
      mem_up2[col] <= rd_up1;
    end
  end

  logic [VW-1:0] tap_q [TAPS];
  logic [VW-1:0] tap_d [TAPS];

  always_comb begin
    for (int k = 0; k < TAPS; k++) tap_d[k] = tap_q[k];
    if (step) begin
      for (int r = 0; r < 3; r++) begin
        tap_d[3*r]     = tap_q[3*r + 1];
        tap_d[3*r + 1] = tap_q[3*r + 2];
      end
      tap_d[2] = rd_up2;
      tap_d[5] = rd_up1;
      tap_d[8] = pix;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) for (int k = 0; k < TAPS; k++) tap_q[k] <= '0;
    else        for (int k = 0; k < TAPS; k++) tap_q[k] <= tap_d[k];
  end

  for (genvar k = 0; k < TAPS; k++) begin : g_out
    assign win[k*VW +: VW] = tap_q[k];
  end
endmodule

// File: rtl/binconv_mac.sv
module binconv_mac
  import binconv_pkg::*;
#(
  parameter int NI    = 8,
  parameter int DW    = 16,
  parameter int SH    = 8,
  localparam int ACCW = DW + $clog2(NI * TAPS),
  localparam int PW   = ACCW + DW
) (
  input  logic [TAPS*NI*DW-1:0]  win,
  input  logic [TAPS-1:0]        mask,
  input  logic [NI*TAPS-1:0]     wgt,
  input  logic signed [DW-1:0]   scale,
  input  logic signed [DW-1:0]   bias,
  output logic [DW-1:0]          y
);
  localparam logic signed [PW:0] HI = (PW+1)'((2 ** (DW - 1)) - 1);
  localparam logic signed [PW:0] LO = -HI - (PW+1)'(1);

  logic signed [ACCW-1:0] acc;
  logic signed [DW-1:0]   px;

  // Sign-weighted sum: each tap adds or subtracts, masked taps are padding zeros.
  always_comb begin
    acc = '0;
    px  = '0;
    for (int i = 0; i < NI; i++) begin
      for (int k = 0; k < TAPS; k++) begin
        px = win[(k*NI + i)*DW +: DW];
        if (mask[k]) acc = wgt[i*TAPS + k] ? acc + ACCW'(px) : acc - ACCW'(px);
      end
    end
  end

  logic signed [PW-1:0] prod;
  logic signed [PW:0]   sum;

  assign prod = PW'(acc) * PW'(scale);
  assign sum  = (PW+1)'(prod >>> SH) + (PW+1)'(bias);

  always_comb begin
    if (sum > HI)      y = {1'b0, {(DW-1){1'b1}}};
    else if (sum < LO) y = {1'b1, {(DW-1){1'b0}}};
    else               y = sum[DW-1:0];
  end
endmodule

// File: rtl/binconv3x3_engine.sv
module binconv3x3_engine
  import binconv_pkg::*;
#(
  parameter int NI   = 8,
  parameter int NO   = 8,
  parameter int DW   = 16,
  parameter int SH   = 8,
  parameter int MAXW = 64,
  parameter int MAXH = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [7:0]         cfg_addr,
  input  logic [DW-1:0]      cfg_wdata,
  input  logic               s_tvalid,
  output logic               s_tready,
  input  logic [NI*DW-1:0]   s_tdata,
  output logic               m_tvalid,
  input  logic               m_tready,
  output logic [NO*DW-1:0]   m_tdata,
  output logic               m_tlast
);
  localparam int AW = $clog2(MAXW);
  localparam int CW = $clog2(MAXW + 1);
  localparam int HW = $clog2(MAXH + 1);
  localparam int RW = $clog2(MAXH + 2);

  // Reset: asserted at once, released through two flops.
  logic [1:0] rs_q;
  logic       arst_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign arst_n = rs_q[1];

  logic [CW-1:0]          width;
  logic [HW-1:0]          height;
  logic [NO*NI*TAPS-1:0]  wgt_all;
  logic [NO*DW-1:0]       scale_all, bias_all;
  logic                   busy;

  binconv_cfg #(.NI(NI), .NO(NO), .DW(DW), .SH(SH), .MAXW(MAXW), .MAXH(MAXH)) cfg_i (
    .clk(clk), .rst_n(arst_n), .busy(busy), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .width(width), .height(height), .wgt(wgt_all),
    .scale(scale_all), .bias(bias_all));

  // Input position (pr_q, pc_q); rows at and past height are self-made zero beats.
  logic [AW-1:0] pc_q, pc_d, cc_q, cc_d, wm1;
  logic [RW-1:0] pr_q, pr_d;
  logic [HW-1:0] cr_q, cr_d;
  logic          wv_q, wv_d, ov_q, ov_d, last_q, last_d;
  logic          en, flushing, step, emit, final_step, at_last;
  logic [NI*DW-1:0] pix_in;
  logic [NO*DW-1:0] dat_q, y_all;

  assign wm1        = AW'(width - CW'(1));
  assign en         = !ov_q || m_tready;
  assign flushing   = pr_q >= RW'(height);
  assign s_tready   = arst_n && en && !flushing;
  assign step       = arst_n && en && (flushing || s_tvalid);
  assign emit       = (pr_q >= RW'(2)) || (pr_q == RW'(1) && pc_q != '0);
  assign final_step = (pr_q == RW'(height) + RW'(1)) && (pc_q == '0);
  assign pix_in     = flushing ? '0 : s_tdata;
  assign at_last    = (cr_q == HW'(height - HW'(1))) && (cc_q == wm1);
  assign busy       = (pr_q != '0) || (pc_q != '0) || wv_q || ov_q;

  always_comb begin
    pc_d   = pc_q;
    pr_d   = pr_q;
    cr_d   = cr_q;
    cc_d   = cc_q;
    wv_d   = wv_q;
    ov_d   = ov_q;
    last_d = last_q;
    if (en) begin
      wv_d   = step && emit;
      ov_d   = wv_q;
      last_d = wv_q && at_last;
    end
    if (step) begin
      if (final_step) begin
        pc_d = '0;
        pr_d = '0;
      end else if (pc_q == wm1) begin
        pc_d = '0;
        pr_d = pr_q + RW'(1);
      end else begin
        pc_d = pc_q + AW'(1);
      end
      // Window centre trails the newest tap by one row and one column.
      if (pc_q == '0) begin
        cc_d = wm1;
        cr_d = HW'(pr_q - RW'(2));
      end else begin
        cc_d = pc_q - AW'(1);
        cr_d = HW'(pr_q - RW'(1));
      end
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      pc_q   <= '0;
      pr_q   <= '0;
      cr_q   <= '0;
      cc_q   <= '0;
      wv_q   <= 1'b0;
      ov_q   <= 1'b0;
      last_q <= 1'b0;
    end else begin
      pc_q   <= pc_d;
      pr_q   <= pr_d;
      cr_q   <= cr_d;
      cc_q   <= cc_d;
      wv_q   <= wv_d;
      ov_q   <= ov_d;
      last_q <= last_d;
    end
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)          dat_q <= '0;
    else if (en && wv_q)  dat_q <= y_all;
  end

  logic [TAPS*NI*DW-1:0] win;
  binconv_window #(.NI(NI), .DW(DW), .MAXW(MAXW)) win_i (
    .clk(clk), .rst_n(arst_n), .step(step), .col(pc_q), .pix(pix_in), .win(win));

  // Border masks: taps outside the image count as zero.
  logic [2:0]      row_ok, col_ok;
  logic [TAPS-1:0] mask;
  assign row_ok = {cr_q != HW'(height - HW'(1)), 1'b1, cr_q != '0};
  assign col_ok = {cc_q != wm1, 1'b1, cc_q != '0};
  for (genvar k = 0; k < TAPS; k++) begin : g_mask
    assign mask[k] = row_ok[k / 3] && col_ok[k % 3];
  end

  for (genvar o = 0; o < NO; o++) begin : g_mac
    binconv_mac #(.NI(NI), .DW(DW), .SH(SH)) mac_i (
      .win(win), .mask(mask), .wgt(wgt_all[o*NI*TAPS +: NI*TAPS]),
      .scale(scale_all[o*DW +: DW]), .bias(bias_all[o*DW +: DW]),
      .y(y_all[o*DW +: DW]));
  end

  assign m_tvalid = ov_q;
  assign m_tdata  = dat_q;
  assign m_tlast  = last_q;

  assert_hold_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast)));

  assert_backpressure_R6: assert property (@(posedge clk) disable iff (!arst_n)
    (m_tvalid && !m_tready) |-> !s_tready);

  assert_centre_in_frame_R4: assert property (@(posedge clk) disable iff (!arst_n)
    wv_q |-> ((CW'(cc_q) < width) && (cr_q < height)));

  assert_rows_bounded_R4: assert property (@(posedge clk) disable iff (!arst_n)
    pr_q <= RW'(height) + RW'(1));

  assert_out_from_window_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(m_tvalid) |-> $past(wv_q));
endmodule

// File: tb/binconv3x3_engine_tb.sv
`timescale 1ns/1ps
module binconv3x3_engine_tb_top;
  localparam int NI = 8;
  localparam int NO = 8;
  localparam int DW = 16;
  localparam int MAXPIX = 512;

  // Stimulus table: width, height, seed, ready mode, valid mode, pixel amplitude, expected beats.
  localparam int NV = 7;
  localparam int VEC [NV][7] = '{
    '{ 8,  6, 11, 0, 0,  2048,  48},
    '{ 5,  4, 22, 1, 1,  2048,  20},
    '{64,  2, 33, 1, 0,  1024, 128},
    '{ 1,  1, 44, 0, 1, 32767,   1},
    '{ 1,  5, 55, 2, 1,   512,   5},
    '{ 7,  1, 66, 1, 2, 30000,   7},
    '{16, 16, 77, 2, 2,  4096, 256}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic            rst_n, cfg_we, s_tvalid, s_tready, m_tvalid, m_tready, m_tlast;
  logic [7:0]      cfg_addr;
  logic [DW-1:0]   cfg_wdata;
  logic [NI*DW-1:0] s_tdata;
  logic [NO*DW-1:0] m_tdata;

  binconv3x3_engine dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .s_tvalid(s_tvalid), .s_tready(s_tready), .s_tdata(s_tdata),
    .m_tvalid(m_tvalid), .m_tready(m_tready), .m_tdata(m_tdata), .m_tlast(m_tlast));

  int n_chk = 0;
  int n_bad = 0;
  int fw, fh;
  logic [31:0] rs = 32'h1234_5678;
  logic signed [15:0] img [NI][MAXPIX];
  logic [8:0]         wb  [NO][NI];
  logic signed [15:0] scl [NO];
  logic signed [15:0] bia [NO];

  function automatic logic [31:0] nxt();
    rs = rs ^ (rs << 13);
    rs = rs ^ (rs >> 17);
    rs = rs ^ (rs << 5);
    return rs;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_out(int o, int r, int c);
    longint acc = 0;
    longint p;
    for (int i = 0; i < NI; i++)
      for (int dy = -1; dy <= 1; dy++)
        for (int dx = -1; dx <= 1; dx++) begin
          int rr = r + dy;
          int cc = c + dx;
          if (rr >= 0 && rr < fh && cc >= 0 && cc < fw) begin
            longint v = longint'(img[i][rr*fw + cc]);
            if (wb[o][i][(dy+1)*3 + (dx+1)]) acc += v; else acc -= v;
          end
        end
    p = (acc * longint'(scl[o])) >>> 8;
    p = p + longint'(bia[o]);
    if (p > 32767) p = 32767;
    if (p < -32768) p = -32768;
    return int'(p);
  endfunction

  task automatic cfg_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic load_cfg();
    cfg_write(8'h00, 16'(fw));
    cfg_write(8'h01, 16'(fh));
    for (int o = 0; o < NO; o++) begin
      for (int i = 0; i < NI; i++) cfg_write(8'(8'h40 + 8*o + i), {7'd0, wb[o][i]});
      cfg_write(8'(8'h80 + o), scl[o]);
      cfg_write(8'(8'h88 + o), bia[o]);
    end
  endtask

  // Random frame content and coefficients of bounded amplitude.
  task automatic gen(input int amp);
    for (int i = 0; i < NI; i++)
      for (int p = 0; p < fw*fh; p++)
        img[i][p] = 16'(int'(nxt() % (2*amp + 1)) - amp);
    for (int o = 0; o < NO; o++) begin
      for (int i = 0; i < NI; i++) wb[o][i] = nxt()[8:0];
      scl[o] = 16'(int'(nxt() % 512) - 256);
      bia[o] = 16'(int'(nxt() % 8192) - 4096);
    end
  endtask

  function automatic bit pick(int mode);
    logic [31:0] v = nxt();
    if (mode == 0) return 1'b1;
    if (mode == 1) return v[0];
    return v[1:0] == 2'b00;
  endfunction

  // Streams one frame, compares every output beat; mid != 0 tries register writes mid-frame.
  task automatic run_frame(input int rmode, input int vmode, input int mid, input string tag);
    int ib = 0;
    int ob = 0;
    int cyc = 0;
    int proto_bad = 0;
    logic [NO*DW-1:0] prev_d = '0;
    logic prev_l = 1'b0;
    bit prev_stall = 1'b0;
    while (ob < fw*fh && cyc < 20000) begin
      @(negedge clk);
      m_tready = pick(rmode);
      s_tvalid = (ib < fw*fh) && pick(vmode);
      for (int i = 0; i < NI; i++) s_tdata[i*DW +: DW] = (ib < fw*fh) ? img[i][ib] : 16'd0;
      cfg_we = 1'b0;
      if (mid != 0 && ib >= 3) begin
        cfg_we = 1'b1;
        cfg_addr = (cyc % 2 == 0) ? 8'h80 : 8'h00;
        cfg_wdata = 16'h0003;
      end
      #1;
      if (prev_stall && (m_tdata != prev_d || m_tlast != prev_l || !m_tvalid)) proto_bad++;
      if (m_tvalid && !m_tready && s_tready) proto_bad++;
      if (s_tvalid && s_tready) ib++;
      if (m_tvalid && m_tready) begin
        int r = ob / fw;
        int c = ob % fw;
        int nbad = 0;
        for (int o = 0; o < NO; o++) begin
          logic signed [15:0] got = m_tdata[o*DW +: DW];
          int e = ref_out(o, r, c);
          if (int'(got) != e) begin
            nbad++;
            $display("FAIL R2/R3/R8 %s pixel (%0d,%0d) ch %0d: actual %0d expected %0d",
                     tag, r, c, o, got, e);
          end
        end
        n_chk++;
        if (nbad != 0) n_bad++;
        check(m_tlast == (ob == fw*fh - 1), "R5 tlast", longint'(m_tlast), longint'(ob == fw*fh - 1));
        ob++;
      end
      prev_stall = m_tvalid && !m_tready;
      prev_d = m_tdata;
      prev_l = m_tlast;
      cyc++;
    end
    @(negedge clk);
    cfg_we = 1'b0; s_tvalid = 1'b0; m_tready = 1'b1;
    check(ob == fw*fh, "R4 beat count", longint'(ob), longint'(fw*fh));
    check(proto_bad == 0, "R6 stall/backpressure", longint'(proto_bad), 0);
    begin
      int extra = 0;
      for (int t = 0; t < 8; t++) begin
        @(negedge clk); #1;
        if (m_tvalid) extra++;
      end
      check(extra == 0, "R4 no extra beats", longint'(extra), 0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    s_tvalid = 1'b0; s_tdata = '0; m_tready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: idle state after reset
    check(m_tvalid == 1'b0, "R1 m_tvalid", longint'(m_tvalid), 0);
    check(s_tready == 1'b1, "R1 s_tready", longint'(s_tready), 1);

    // Table walk: R2, R3, R4, R5, R6, R8, and R9 since frames of differing size follow unreset.
    for (int v = 0; v < NV; v++) begin
      fw = VEC[v][0];
      fh = VEC[v][1];
      rs = 32'(VEC[v][2]) * 32'h9E37_79B9 + 32'd1;
      gen(VEC[v][5]);
      check(fw*fh == VEC[v][6], "R4 table size", longint'(fw*fh), longint'(VEC[v][6]));
      load_cfg();
      run_frame(VEC[v][3], VEC[v][4], 0, "R9 table");
    end

    // R3: positive saturation with full-scale pixels and all-plus weights.
    fw = 4; fh = 3;
    for (int i = 0; i < NI; i++) for (int p = 0; p < fw*fh; p++) img[i][p] = 16'sd32767;
    for (int o = 0; o < NO; o++) begin
      for (int i = 0; i < NI; i++) wb[o][i] = 9'h1FF;
      scl[o] = 16'sd256; bia[o] = 16'sd0;
    end
    check(ref_out(0, 1, 1) == 32767, "R3 model high clamp", longint'(ref_out(0, 1, 1)), 32767);
    load_cfg();
    run_frame(1, 0, 0, "R3 high clamp");

    // R3: negative saturation with all-minus weights.
    for (int o = 0; o < NO; o++) for (int i = 0; i < NI; i++) wb[o][i] = 9'h000;
    check(ref_out(3, 0, 0) == -32768, "R3 model low clamp", longint'(ref_out(3, 0, 0)), -32768);
    load_cfg();
    run_frame(0, 1, 0, "R3 low clamp");

    // R7: scale and width writes during a frame must not change its outputs or length.
    fw = 9; fh = 4;
    gen(1500);
    load_cfg();
    run_frame(1, 1, 1, "R7 mid-frame write");
    // R9: the same configuration again right after, without reset.
    run_frame(2, 0, 0, "R9 repeat frame");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule